// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

A bank of interrupt detectors for a group of general-purpose input pins. Every pin is first brought into the clock domain by a short flop chain, and then watched by its own detector. Each pin has three configuration bits:

- A type bit chooses whether the pin reports edges or levels.
- A polarity bit chooses rising or falling edges in edge mode, and a high or a low level in level mode.
- An any-edge bit makes an edge-mode pin respond to both edges.

A detected condition sets a sticky status bit. Software clears a status bit by writing a one to it. That write works only in a cycle in which the pin's condition is absent, so a level source that is still active cannot be acknowledged away. A per-pin mask gates only whether status reaches the single registered interrupt output. Detection and status capture continue while a pin is masked, so an edge that arrives during handling is seen once the pin is unmasked.

Configuration, mask and acknowledge go through a simple synchronous port. A write is one cycle with `wr_en_i` high. A read is combinational from `addr_i`.

Top module: `gpio_irq_bank`

## Requirements
- R1: In edge mode (type bit 0), polarity 1 detects a rising edge and polarity 0 detects a falling edge. When a pin changes just after a clock edge, its status bit reads 1 after the third following rising clock edge, and not after the second.
- R2: When the any-edge bit is 1 and the pin is in edge mode, both rising and falling edges set status, whatever the polarity.
- R3: In level mode (type bit 1), polarity 1 makes a high level the condition and polarity 0 makes a low level the condition. Status stays 1 while the condition is present, even when it is acknowledged.
- R4: A write of 1 to a status bit at address 4 clears it when the pin's condition is absent in that cycle. Writing 0 to a status bit leaves it unchanged.
- R5: When a new condition and an acknowledge fall in the same cycle, status stays set.
- R6: `irq_o` is a register that holds the OR over all pins of (status AND NOT mask). It follows one clock after status or mask changes. A mask bit of 1 disables its pin.
- R7: Masking does not stop detection. A pin that is masked still sets its status bit, and unmasking that pin then asserts `irq_o`.
- R8: After reset, status reads 0, mask reads all ones, type reads 0, polarity reads all ones, any-edge reads 0 and `irq_o` is 0.
- R9: Writing the type, polarity or any-edge register does not by itself clear a status bit.
- R10: The register map is:
  - address 0: type
  - address 1: polarity
  - address 2: any-edge
  - address 3: mask
  - address 4: status, read, and write 1 to clear
  - address 5: synchronized pin values, read only

  Bit n of each register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw pin inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| rdata_o | output | NUM_PINS | Read data for `addr_i` |
| irq_o | output | 1 | Aggregated interrupt, registered |

## Verification
Single rising and falling edges are driven, with and without the any-edge bit, to show that the polarity decode and the both-edge path are separate. One edge is also sampled cycle by cycle to pin down the sync and detect latency.

Level-high and level-low conditions are acknowledged both while active and after they go away. This separates a gated clear from a plain write-one-to-clear.

An edge timed so that it lands in the same cycle as an acknowledge separates set-wins from clear-wins. Masked edges followed by an unmask show that masking gates propagation only. A configuration rewrite over a set status bit shows that status survives it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_TYPE = 3'd0,
    RA_POL  = 3'd1,
    RA_ANY  = 3'd2,
    RA_MASK = 3'd3,
    RA_STAT = 3'd4,
    RA_PIN  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= '0;
      end else if (s == 0) begin
        stg_q[s] <= d_i;
      end else begin
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] level_mode_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] any_i,
  input  logic [NUM_PINS-1:0] ack_i,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = sync_i[i] & ~prev_q[i];
    assign fall     = ~sync_i[i] & prev_q[i];
    assign edge_hit = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign lvl_hit  = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign cond[i]  = level_mode_i[i] ? lvl_hit : edge_hit;

    // set has priority over acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else         status_q[i] <= cond[i] | (status_q[i] & ~ack_i[i]);
    end

    p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cond[i] |=> status_q[i]);
    p_level_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_mode_i[i] && lvl_hit && ack_i[i]) |=> status_q[i]);
    p_ack_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !cond[i]) |=> !status_q[i]);
    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ack_i[i] && status_q[i]) |=> status_q[i]);
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   status_i,
  input  logic [NUM_PINS-1:0]   sync_i,
  output logic [NUM_PINS-1:0]   level_mode_o,
  output logic [NUM_PINS-1:0]   pol_o,
  output logic [NUM_PINS-1:0]   any_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   ack_o,
  output logic [NUM_PINS-1:0]   rdata_o
);
  logic [NUM_PINS-1:0] type_q, pol_q, any_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      pol_q  <= '1;
      any_q  <= '0;
      mask_q <= '1;
    end else if (wr_en_i) begin
      case (addr_i)
        RA_TYPE: type_q <= wdata_i;
        RA_POL:  pol_q  <= wdata_i;
        RA_ANY:  any_q  <= wdata_i;
        RA_MASK: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (wr_en_i && addr_i == RA_STAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      RA_TYPE: rdata_o = type_q;
      RA_POL:  rdata_o = pol_q;
      RA_ANY:  rdata_o = any_q;
      RA_MASK: rdata_o = mask_q;
      RA_STAT: rdata_o = status_i;
      RA_PIN:  rdata_o = sync_i;
      default: rdata_o = '0;
    endcase
  end

  assign level_mode_o = type_q;
  assign pol_o        = pol_q;
  assign any_o        = any_q;
  assign mask_o       = mask_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] sync, level_mode, pol, any_edge, mask, ack, status;
  logic                irq_q;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status), .sync_i(sync),
    .level_mode_o(level_mode), .pol_o(pol), .any_o(any_edge),
    .mask_o(mask), .ack_o(ack), .rdata_o(rdata_o)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .level_mode_i(level_mode),
    .pol_i(pol), .any_i(any_edge), .ack_i(ack), .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & ~mask);
  end

  assign irq_o = irq_q;

  p_irq_raise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & ~mask) != '0) |=> irq_o);
  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & ~mask) == '0) |=> !irq_o);
  p_masked_detect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask[0] && !level_mode[0] && !any_edge[0] && pol[0] && $rose(sync[0]))
      |=> status[0]);
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pin = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;
  int           n_tests = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(4, v); chk("R8 status", v, 8'h00);
    rd(3, v); chk("R8 mask", v, 8'hFF);
    rd(0, v); chk("R8 type", v, 8'h00);
    rd(1, v); chk("R8 pol", v, 8'hFF);
    rd(2, v); chk("R8 any", v, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    logic [N-1:0] v;
    wr(3, 8'hFE);
    @(negedge clk); pin[0] = 1'b1; addr = 4;
    @(negedge clk);
    @(negedge clk); #1 chk("R1 latency not yet", rdata, 8'h00);
    @(negedge clk); #1 chk("R1 rise set", rdata, 8'h01);
    @(negedge clk); #1 chk("R6 irq on", {7'b0, irq}, 8'h01);
    wr(4, 8'h01); settle();
    rd(4, v); chk("R4 edge ack", v, 8'h00);
    chk("R6 irq off", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    wr(1, 8'hFE);
    @(negedge clk); pin[0] = 1'b0; settle();
    rd(4, v); chk("R1 fall set", v, 8'h01);
    wr(4, 8'h01);
    @(negedge clk); pin[0] = 1'b1; settle();
    rd(4, v); chk("R1 rise ignored when falling", v, 8'h00);
    wr(1, 8'hFF);
  endtask

  task automatic t_any();
    logic [N-1:0] v;
    wr(2, 8'h02);
    @(negedge clk); pin[1] = 1'b1; settle();
    rd(4, v); chk("R2 any rise", v, 8'h02);
    wr(4, 8'h02);
    @(negedge clk); pin[1] = 1'b0; settle();
    rd(4, v); chk("R2 any fall", v, 8'h02);
    wr(4, 8'h02); wr(2, 8'h00);
    rd(4, v); chk("R2 cleared", v, 8'h00);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    wr(0, 8'h04);
    @(negedge clk); pin[2] = 1'b1; settle();
    rd(4, v); chk("R3 level high set", v, 8'h04);
    wr(4, 8'h04); settle();
    rd(4, v); chk("R3 ack while active", v, 8'h04);
    @(negedge clk); pin[2] = 1'b0; settle();
    rd(4, v); chk("R3 sticky after release", v, 8'h04);
    wr(4, 8'h04);
    rd(4, v); chk("R4 level ack after release", v, 8'h00);
    wr(1, 8'hFB); settle();
    rd(4, v); chk("R3 level low set", v, 8'h04);
    wr(1, 8'hFF); wr(4, 8'h04);
    rd(4, v); chk("R3 low cleared", v, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_write_zero();
    logic [N-1:0] v;
    @(negedge clk); pin[3] = 1'b1; settle();
    wr(4, 8'h00);
    rd(4, v); chk("R4 write zero", v, 8'h08);
    wr(4, 8'h08);
  endtask

  task automatic t_set_wins();
    logic [N-1:0] v;
    wr(2, 8'h10);
    @(negedge clk); pin[4] = 1'b1; settle();
    @(negedge clk); pin[4] = 1'b0;
    @(negedge clk);
    wr(4, 8'h10);
    rd(4, v); chk("R5 set wins", v, 8'h10);
    wr(4, 8'h10);
    rd(4, v); chk("R5 later ack", v, 8'h00);
    wr(2, 8'h00);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    wr(3, 8'hFF);
    @(negedge clk); pin[5] = 1'b1; pin[6] = 1'b1; settle();
    rd(4, v); chk("R7 masked status", v, 8'h60);
    chk("R6 masked irq", {7'b0, irq}, 8'h00);
    wr(3, 8'hBF);
    @(negedge clk); #1 chk("R7 unmask irq", {7'b0, irq}, 8'h01);
    wr(4, 8'h40);
    @(negedge clk); #1 chk("R6 other pin masked", {7'b0, irq}, 8'h00);
    wr(3, 8'hDF);
    @(negedge clk); #1 chk("R6 OR second pin", {7'b0, irq}, 8'h01);
    wr(4, 8'h20);
  endtask

  task automatic t_cfg_keep();
    logic [N-1:0] v;
    @(negedge clk); pin[7] = 1'b1; settle();
    wr(0, 8'h80); wr(1, 8'h7F); wr(2, 8'h80);
    rd(4, v); chk("R9 config keeps status", v, 8'h80);
    wr(0, 8'h00); wr(1, 8'hFF); wr(2, 8'h00); wr(4, 8'h80);
    rd(4, v); chk("R9 cleared after restore", v, 8'h00);
    rd(5, v); chk("R10 pin readback", v, pin);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_any();
    t_level();
    t_write_zero();
    t_set_wins();
    t_mask();
    t_cfg_keep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule